// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers requests from 32 interrupt sources and hands a single processor one request line together with the 5-bit number of the source it should service. Each source is configured through static inputs: an enable bit, a 2-bit trigger type (active-low level, active-high level, falling edge or rising edge) and a 3-bit priority. Edge events are held in a per-source latch. Level sources are sampled every cycle and are not held.

Among the pending, enabled sources, the controller selects the one with the highest priority. It breaks ties in favour of the lowest source number. When the processor acknowledges the request, the controller pushes that source's priority onto an eight-entry nesting stack. From then on, only requests of strictly higher priority may interrupt. An end-of-service pulse pops one level and restores the previous threshold.

Top module: `pri_intc`

## Requirements
- R1: The trigger field of source i is bits [2i+1:2i] of `src_trig_i`, encoded as 00 = active-low level, 01 = active-high level, 10 = falling edge and 11 = rising edge. A level source requests only while its sampled input matches its active level, and its request disappears when the input returns to the inactive level.
- R2: An edge source latches one event when its input makes the configured transition. The request stays pending after the input returns to its idle level and lasts until that source is acknowledged. The opposite transition raises no request.
- R3: A source whose `src_en_i` bit is 0 is never presented. An edge event that arrives while the source is disabled stays latched and is presented once the source is enabled.
- R4: Priority i is bits [3i+2:3i] of `src_prio_i`, and 7 is the most urgent level. The presented source is the eligible one with the numerically largest priority.
- R5: When several eligible sources share the largest priority, the lowest-numbered source is presented.
- R6: A change on `src_i` shows on `irq_o` after the second rising clock edge. `vec_o` and `prio_o` carry the winner's number and priority in every cycle in which `irq_o` is 1.
- R7: `ack_i` sampled high while `irq_o` is 1 does three things. It pushes `prio_o` onto the stack, so `depth_o` rises by one and `lvl_o` becomes that priority. It clears that source's edge latch. It holds `irq_o` low for the following cycle.
- R8: While `depth_o` is non-zero, only sources whose priority is strictly greater than `lvl_o` are eligible. The stack never holds more than DEPTH levels.
- R9: `eoi_i` with a non-empty stack pops one level and holds `irq_o` low for the following cycle. `eoi_i` with an empty stack is ignored. When `eoi_i` and a valid acknowledge arrive together, only the acknowledge takes effect.
- R10: `ack_i` while `irq_o` is 0 changes nothing.
- R11: After reset, `irq_o` is 0, `depth_o` is 0, `lvl_o` is 0, and all edge latches are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw interrupt source inputs |
| src_en_i | input | 32 | Per-source enable (1 = may be presented) |
| src_trig_i | input | 64 | Per-source 2-bit trigger type |
| src_prio_i | input | 96 | Per-source 3-bit priority |
| ack_i | input | 1 | Processor acknowledge of the presented request |
| eoi_i | input | 1 | End of service, pops one nesting level |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 5 | Number of the presented source |
| prio_o | output | 3 | Priority of the presented source |
| lvl_o | output | 3 | Priority currently in service (top of stack, 0 if empty) |
| depth_o | output | 4 | Number of nested levels in service |

## Verification
A source change lands in the sampling register at the first rising edge and in the request register at the second. The bench therefore checks one negative edge after the first rising edge, where the request must still be absent, and one negative edge after the second, where it must be present.

An acknowledge or end-of-service pulse acts at a single rising edge. Its effects on the stack and on `irq_o` are checked at the next negative edge. The newly chosen winner is checked one further cycle later.

The driver queues each expected value at the negative edge where it is due. The monitor compares it a few time units later, so no check samples near a rising edge.

// File: rtl/pri_intc_pkg.sv
package pri_intc_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_e;

endpackage

// File: rtl/pri_intc_detect.sv
module pri_intc_detect
    import pri_intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [2*NSRC-1:0] trig_i,
    input  logic [NSRC-1:0]   clr_i,
    output logic [NSRC-1:0]   req_o
);

    typedef struct packed {
        logic [NSRC-1:0] smp;
        logic [NSRC-1:0] pend;
    } det_t;

    det_t st_d, st_q;

    logic [NSRC-1:0] ev;
    logic [NSRC-1:0] is_edge;
    logic [NSRC-1:0] lvl_hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        trig_e t;
        assign t          = trig_e'(trig_i[2*i +: 2]);
        assign is_edge[i] = (t == TRIG_FALL) || (t == TRIG_RISE);
        assign ev[i]      = (t == TRIG_RISE) ? (src_i[i] & ~st_q.smp[i]) :
                            (t == TRIG_FALL) ? (~src_i[i] & st_q.smp[i]) : 1'b0;
        assign lvl_hit[i] = (t == TRIG_HIGH) ? st_q.smp[i] :
                            (t == TRIG_LOW)  ? ~st_q.smp[i] : 1'b0;
        assign req_o[i]   = is_edge[i] ? st_q.pend[i] : lvl_hit[i];
    end

    always_comb begin
        st_d      = st_q;
        st_d.smp  = src_i;
        // a fresh event wins over a clear in the same cycle
        st_d.pend = ((st_q.pend & ~clr_i) | ev) & is_edge;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pri_intc_arb.sv
module pri_intc_arb #(
    parameter int NSRC = 32,
    parameter int PW   = 3,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]    req_i,
    input  logic [NSRC-1:0]    en_i,
    input  logic [PW*NSRC-1:0] prio_i,
    input  logic               thr_valid_i,
    input  logic [PW-1:0]      thr_i,
    output logic               hit_o,
    output logic [IW-1:0]      idx_o,
    output logic [PW-1:0]      pri_o
);

    logic [PW-1:0] p;

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        pri_o = '0;
        p     = '0;
        for (int i = 0; i < NSRC; i++) begin
            p = prio_i[PW*i +: PW];
            // strict compare keeps the lowest index on ties
            if (req_i[i] && en_i[i] && (!thr_valid_i || p > thr_i) &&
                (!hit_o || p > pri_o)) begin
                hit_o = 1'b1;
                idx_o = IW'(i);
                pri_o = p;
            end
        end
    end

endmodule

// File: rtl/pri_intc_stack.sv
module pri_intc_stack #(
    parameter int PW    = 3,
    parameter int DEPTH = 8,
    localparam int DW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [PW-1:0] lvl_i,
    input  logic          pop_i,
    output logic [PW-1:0] top_o,
    output logic [DW-1:0] depth_o
);

    typedef struct packed {
        logic [DEPTH-1:0][PW-1:0] lvl;
        logic [DW-1:0]            depth;
    } stk_t;

    stk_t st_d, st_q;

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] top_ptr;

    assign wr_ptr  = AW'(st_q.depth);
    assign top_ptr = AW'(st_q.depth - 1'b1);
    assign top_o   = (st_q.depth == '0) ? '0 : st_q.lvl[top_ptr];
    assign depth_o = st_q.depth;

    always_comb begin
        st_d = st_q;
        if (push_i && st_q.depth < DW'(DEPTH)) begin
            st_d.lvl[wr_ptr] = lvl_i;
            st_d.depth       = st_q.depth + 1'b1;
        end else if (pop_i && st_q.depth != '0) begin
            st_d.depth = st_q.depth - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pri_intc.sv
module pri_intc #(
    parameter int NSRC  = 32,
    parameter int PW    = 3,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(NSRC),
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [NSRC-1:0]   src_en_i,
    input  logic [2*NSRC-1:0] src_trig_i,
    input  logic [PW*NSRC-1:0] src_prio_i,
    input  logic              ack_i,
    input  logic              eoi_i,
    output logic              irq_o,
    output logic [IW-1:0]     vec_o,
    output logic [PW-1:0]     prio_o,
    output logic [PW-1:0]     lvl_o,
    output logic [DW-1:0]     depth_o
);

    typedef struct packed {
        logic          irq;
        logic [IW-1:0] vec;
        logic [PW-1:0] pri;
    } out_t;

    out_t st_d, st_q;

    logic [NSRC-1:0] req;
    logic [NSRC-1:0] clr;
    logic            hit;
    logic [IW-1:0]   win_idx;
    logic [PW-1:0]   win_pri;
    logic [PW-1:0]   top;
    logic [DW-1:0]   depth;
    logic            ack_ok;
    logic            pop_ok;

    assign ack_ok = ack_i & st_q.irq;
    assign pop_ok = eoi_i & ~ack_ok & (depth != '0);
    assign clr    = ack_ok ? (NSRC'(1) << st_q.vec) : '0;

    pri_intc_detect #(.NSRC(NSRC)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .trig_i (src_trig_i),
        .clr_i  (clr),
        .req_o  (req)
    );

    pri_intc_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
        .req_i       (req),
        .en_i        (src_en_i),
        .prio_i      (src_prio_i),
        .thr_valid_i (depth != '0),
        .thr_i       (top),
        .hit_o       (hit),
        .idx_o       (win_idx),
        .pri_o       (win_pri)
    );

    pri_intc_stack #(.PW(PW), .DEPTH(DEPTH)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (ack_ok),
        .lvl_i   (st_q.pri),
        .pop_i   (pop_ok),
        .top_o   (top),
        .depth_o (depth)
    );

    always_comb begin
        st_d     = st_q;
        // a stack change forces one idle cycle so the next pick sees the new threshold
        st_d.irq = hit & ~ack_ok & ~pop_ok;
        st_d.vec = hit ? win_idx : '0;
        st_d.pri = hit ? win_pri : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o   = st_q.irq;
    assign vec_o   = st_q.vec;
    assign prio_o  = st_q.pri;
    assign lvl_o   = top;
    assign depth_o = depth;

endmodule

// File: rtl/pri_intc_chk.sv
module pri_intc_chk #(
    parameter int NSRC  = 32,
    parameter int PW    = 3,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(NSRC),
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_en_i,
    input logic            ack_i,
    input logic            eoi_i,
    input logic            irq_o,
    input logic [IW-1:0]   vec_o,
    input logic [PW-1:0]   prio_o,
    input logic [PW-1:0]   lvl_o,
    input logic [DW-1:0]   depth_o
);

    logic [NSRC-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= src_en_i;
    end

    assert_winner_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> en_q[vec_o]);

    assert_ack_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (!irq_o && depth_o == $past(depth_o) + 1'b1 && lvl_o == $past(prio_o)));

    assert_nest_above_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && depth_o != '0) |-> (prio_o > lvl_o));

    assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= DW'(DEPTH));

    assert_eoi_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(ack_i && irq_o) && depth_o != '0) |=> (!irq_o && depth_o == $past(depth_o) - 1'b1));

    assert_idle_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !irq_o && !eoi_i) |=> (depth_o == $past(depth_o)));

endmodule

bind pri_intc pri_intc_chk #(.NSRC(NSRC), .PW(PW), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_en_i (src_en_i),
    .ack_i    (ack_i),
    .eoi_i    (eoi_i),
    .irq_o    (irq_o),
    .vec_o    (vec_o),
    .prio_o   (prio_o),
    .lvl_o    (lvl_o),
    .depth_o  (depth_o)
);

// File: tb/sim_pri_intc.sv
`timescale 1ns/1ps
module sim_pri_intc;

    localparam int NSRC = 32;
    localparam int PW   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src = '0;
    logic [NSRC-1:0]   en = '0;
    logic [2*NSRC-1:0] trig = '0;
    logic [PW*NSRC-1:0] prio = '0;
    logic              ack = 1'b0;
    logic              eoi = 1'b0;
    logic              irq;
    logic [4:0]        vec;
    logic [2:0]        pri;
    logic [2:0]        lvl;
    logic [3:0]        depth;

    always #5 clk = ~clk;

    pri_intc u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src),
        .src_en_i   (en),
        .src_trig_i (trig),
        .src_prio_i (prio),
        .ack_i      (ack),
        .eoi_i      (eoi),
        .irq_o      (irq),
        .vec_o      (vec),
        .prio_o     (pri),
        .lvl_o      (lvl),
        .depth_o    (depth)
    );

    typedef struct {
        bit irq;
        int vec;
        int pri;
        int dep;
        int lvl;
    } exp_t;

    exp_t  q[$];
    string tq[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input bit i, input int v, input int p,
                              input int d, input int l);
        exp_t e;
        e.irq = i; e.vec = v; e.pri = p; e.dep = d; e.lvl = l;
        q.push_back(e);
        tq.push_back(tag);
    endtask

    task automatic set_src(input int i, input bit e, input logic [1:0] t, input int p);
        en[i]             = e;
        trig[2*i +: 2]    = t;
        prio[PW*i +: PW]  = PW'(p);
    endtask

    task automatic ack_pulse();
        ack = 1'b1; tick(1); ack = 1'b0;
    endtask

    task automatic eoi_pulse();
        eoi = 1'b1; tick(1); eoi = 1'b0;
    endtask

    // monitor: compares queued expectations shortly after each falling edge
    always @(negedge clk) begin
        #2;
        while (q.size() > 0) begin
            exp_t  e;
            string t;
            bit    bad;
            e = q.pop_front();
            t = tq.pop_front();
            bad = (irq !== e.irq) || (depth !== 4'(e.dep)) || (lvl !== 3'(e.lvl));
            if (e.irq) bad = bad || (vec !== 5'(e.vec)) || (pri !== 3'(e.pri));
            n_chk++;
            if (bad) begin
                n_fail++;
                $display("FAIL %s: actual irq=%0d vec=%0d prio=%0d depth=%0d lvl=%0d expected irq=%0d vec=%0d prio=%0d depth=%0d lvl=%0d",
                         t, irq, vec, pri, depth, lvl, e.irq, e.vec, e.pri, e.dep, e.lvl);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSRC; i++) trig[2*i +: 2] = 2'b01;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_out("R11 reset state", 0, 0, 0, 0, 0);

        // R1 / R6: high level source, two edge latency
        set_src(3, 1, 2'b01, 2);
        src[3] = 1'b1;
        tick(1); expect_out("R6 not yet after one edge", 0, 0, 0, 0, 0);
        tick(1); expect_out("R6 R1 high level presented", 1, 3, 2, 0, 0);
        src[3] = 1'b0;
        tick(2); expect_out("R1 level not held", 0, 0, 0, 0, 0);

        // R1 low level, R3 masking
        set_src(4, 1, 2'b00, 1);
        tick(2); expect_out("R1 low level presented", 1, 4, 1, 0, 0);
        set_src(4, 0, 2'b00, 1);
        tick(2); expect_out("R3 disabled source hidden", 0, 0, 0, 0, 0);

        // R2 rising edge latched
        set_src(5, 1, 2'b11, 3);
        src[5] = 1'b1; tick(1); src[5] = 1'b0; tick(1);
        expect_out("R2 rising edge presented", 1, 5, 3, 0, 0);
        tick(3); expect_out("R2 edge stays latched", 1, 5, 3, 0, 0);
        ack_pulse(); expect_out("R7 ack pushes level", 0, 0, 0, 1, 3);
        tick(1); expect_out("R7 edge latch cleared", 0, 0, 0, 1, 3);
        eoi_pulse(); expect_out("R9 eoi pops", 0, 0, 0, 0, 0);

        // R2 falling edge
        set_src(6, 1, 2'b10, 3);
        src[6] = 1'b1;
        tick(2); expect_out("R2 rise ignored on falling type", 0, 0, 0, 0, 0);
        src[6] = 1'b0;
        tick(2); expect_out("R2 falling edge presented", 1, 6, 3, 0, 0);
        ack_pulse(); expect_out("R7 ack falling source", 0, 0, 0, 1, 3);
        eoi_pulse(); expect_out("R9 eoi after falling", 0, 0, 0, 0, 0);

        // R3 edge kept while disabled
        set_src(7, 0, 2'b11, 4);
        src[7] = 1'b1; tick(1); src[7] = 1'b0; tick(1);
        tick(1); expect_out("R3 masked edge hidden", 0, 0, 0, 0, 0);
        en[7] = 1'b1;
        tick(2); expect_out("R3 masked edge shown after enable", 1, 7, 4, 0, 0);
        ack_pulse(); expect_out("R7 ack masked edge", 0, 0, 0, 1, 4);
        eoi_pulse(); expect_out("R9 eoi masked edge", 0, 0, 0, 0, 0);

        // R4 / R8 / R5 / R9 / R10 nesting
        set_src(8, 1, 2'b01, 2);
        set_src(9, 1, 2'b01, 6);
        set_src(10, 1, 2'b01, 4);
        src[8] = 1'b1; src[9] = 1'b1; src[10] = 1'b1;
        tick(2); expect_out("R4 highest priority wins", 1, 9, 6, 0, 0);
        ack_pulse(); expect_out("R7 ack level source", 0, 0, 0, 1, 6);
        tick(1); expect_out("R8 lower and equal blocked", 0, 0, 0, 1, 6);
        set_src(11, 1, 2'b01, 6);
        src[11] = 1'b1;
        tick(2); expect_out("R8 equal priority blocked", 0, 0, 0, 1, 6);
        set_src(12, 1, 2'b01, 7);
        src[12] = 1'b1;
        tick(2); expect_out("R8 higher priority nests", 1, 12, 7, 1, 6);
        ack_pulse(); expect_out("R7 second push", 0, 0, 0, 2, 7);
        ack_pulse(); expect_out("R10 idle ack ignored", 0, 0, 0, 2, 7);
        eoi_pulse(); expect_out("R9 pop to previous level", 0, 0, 0, 1, 6);
        tick(1); expect_out("R8 level source repicked", 1, 12, 7, 1, 6);
        src[12] = 1'b0;
        tick(2); expect_out("R8 nothing above level", 0, 0, 0, 1, 6);
        eoi_pulse(); expect_out("R9 pop to empty", 0, 0, 0, 0, 0);
        tick(1); expect_out("R5 tie goes to lowest index", 1, 9, 6, 0, 0);
        src[9] = 1'b0;
        tick(2); expect_out("R5 next of tied pair", 1, 11, 6, 0, 0);
        src[9] = 1'b1;
        tick(2); expect_out("R5 tie restored", 1, 9, 6, 0, 0);
        ack = 1'b1; eoi = 1'b1; tick(1); ack = 1'b0; eoi = 1'b0;
        expect_out("R9 ack wins over eoi", 0, 0, 0, 1, 6);
        eoi_pulse(); expect_out("R9 pop after combined", 0, 0, 0, 0, 0);
        eoi_pulse(); expect_out("R9 eoi on empty ignored", 1, 9, 6, 0, 0);

        // R1 all level sources idle
        src = '0;
        tick(2); expect_out("R1 all idle", 0, 0, 0, 0, 0);

        tick(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule